// File: doc/BRIEF.md
# Interrupt Redirection Controller with Message Output

This block keeps one redirection entry per interrupt input line and turns each interrupt that is allowed to go out into a single 32-bit message write. The message write carries a fixed address prefix and a data word. Both are assembled from the fields of the entry that raised the interrupt. At most one message is outstanding at any time. It waits on a valid/ready handshake, and when several inputs want service in the same cycle the lowest-numbered entry goes first.

Software never sees the table directly. It writes an index register to choose an internal register: an identification word, a version word, or one half of a 64-bit redirection entry. It then reads or writes that register through a window register. A third register takes end-of-interrupt writes. The vector in the low byte of such a write clears the remote-pending flag of every entry programmed with that vector. This lets level-triggered inputs deliver again.

Each entry selects edge or level triggering. An edge input sends once per rising edge. A level input sends once and then stays quiet until its remote-pending flag is cleared.

Top module: `irq_redir_msi`

## Requirements
- R1: After reset every entry reads back masked with all other fields zero (low half 0x0001_0000, high half 0x0000_0000), no remote-pending flag is set and `msg_valid` is low.
- R2: `reg_sel` encodes 0 = index, 1 = window, 2 = end-of-interrupt, 3 = unused. The index register reads back its 8-bit value. Index 0x10+2n selects the low half of entry n and 0x11+2n selects its high half. The low half holds vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], remote-pending [14], trigger mode [15] (1 = level) and mask [16]. The high half holds the extended destination ID in [23:16] and the destination ID in [31:24]. Bits 12 and 14 and the reserved bits ignore writes.
- R3: Index 0 is the identification register, of which only bits [27:24] are writable. Index 1 is a read-only version register that reads {8'h00, entry count minus one, 8'h00, 8'h20}, which is 0x0007_0020 with 8 entries.
- R4: Index values that select no implemented register read as zero through the window, and window writes to them change nothing. Reads with `reg_sel` = 3 return zero.
- R5: The message address is {12'hFEE, destination ID, extended destination ID, hint, destination mode, 2'b00}, where hint is 1 exactly when the delivery mode is 3'b001.
- R6: The message data is {16'h0000, trigger mode, 1'b1, 2'b00, destination mode, delivery mode, vector}.
- R7: A masked entry never produces a message. An edge that arrives while the entry is masked is discarded.
- R8: An edge-triggered entry produces exactly one message per rising edge of its input, however long the input stays high.
- R9: When a level-triggered entry's message is accepted, its remote-pending flag is set. The entry produces no further message while that flag is set.
- R10: An end-of-interrupt write clears the remote-pending flag of every entry whose vector equals the written bits [7:0]. Bits [31:8] are ignored, and entries with other vectors keep their flag.
- R11: When several entries request service at once, messages leave in ascending entry order, one at a time.
- R12: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady.
- R13: The delivery status bit of an entry reads 1 while that entry has a request waiting or its message outstanding, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 window, 2 end-of-interrupt |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq_in | input | NUM_ENT | Interrupt input lines, one per entry |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write accepted when high with valid |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
A corrupted entry field surfaces at the ports within a few cycles. It shows either through the window readback or in the address or data of the next message from that entry, where each field has a fixed bit position. A remote-pending flag left set or cleared in error shows up as a level input that stays silent after end-of-interrupt, or as a repeat message in the cycles right after acceptance. A wrong edge-pending bit shows up as a missing, extra or out-of-order message. The scoreboard catches this at the handshake, because messages must leave in a fixed order.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [1:0] SEL_INDEX  = 2'd0;
  localparam logic [1:0] SEL_WINDOW = 2'd1;
  localparam logic [1:0] SEL_EOI    = 2'd2;

  localparam logic [11:0] MSG_PREFIX  = 12'hFEE;
  localparam logic [7:0]  VERSION_NUM = 8'h20;
  localparam logic [2:0]  DLM_HINT    = 3'b001;

  typedef struct packed {
    logic [7:0] did;
    logic [7:0] edid;
    logic       mask;
    logic       tm;
    logic       rirr;
    logic       dsm;
    logic [2:0] dlm;
    logic [7:0] vct;
  } rte_t;

  localparam rte_t RTE_RESET = '{did: 8'd0, edid: 8'd0, mask: 1'b1, tm: 1'b0,
                                 rirr: 1'b0, dsm: 1'b0, dlm: 3'd0, vct: 8'd0};

  function automatic logic [31:0] rte_low(rte_t e, logic ds);
    return {15'd0, e.mask, e.tm, e.rirr, 1'b0, ds, e.dsm, e.dlm, e.vct};
  endfunction

  function automatic logic [31:0] rte_high(rte_t e);
    return {e.did, e.edid, 16'd0};
  endfunction

  function automatic rte_t rte_put_low(rte_t e, logic [31:0] w);
    rte_t r;
    r      = e;
    r.vct  = w[7:0];
    r.dlm  = w[10:8];
    r.dsm  = w[11];
    r.tm   = w[15];
    r.mask = w[16];
    return r;
  endfunction

  function automatic rte_t rte_put_high(rte_t e, logic [31:0] w);
    rte_t r;
    r      = e;
    r.edid = w[23:16];
    r.did  = w[31:24];
    return r;
  endfunction

  function automatic logic [31:0] msi_addr(rte_t e);
    return {MSG_PREFIX, e.did, e.edid, (e.dlm == DLM_HINT), e.dsm, 2'b00};
  endfunction

  function automatic logic [31:0] msi_data(rte_t e);
    return {16'd0, e.tm, 1'b1, 2'b00, e.dsm, e.dlm, e.vct};
  endfunction

endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int         NUM_ENT  = 8,
  parameter logic [7:0] ENT_BASE = 8'h10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_ENT-1:0]   rirr_set,
  input  logic [NUM_ENT-1:0]   ds_vec,
  output rte_t [NUM_ENT-1:0]   ents
);

  localparam int ENT_FIRST = int'(ENT_BASE);
  localparam int ENT_LAST  = ENT_FIRST + 2 * NUM_ENT - 1;
  localparam logic [31:0] VERSION_WORD = {8'd0, 8'(NUM_ENT - 1), 8'd0, VERSION_NUM};

  logic [7:0]         idx_q;
  logic [3:0]         apic_id_q;
  rte_t               ent_q   [NUM_ENT];
  rte_t               ent_nxt [NUM_ENT];
  logic [7:0]         off;
  logic               in_tab;
  logic               hi_half;
  logic [NUM_ENT-1:0] ent_hit;
  logic               idx_we, win_we, eoi_we;
  logic [31:0]        win_rd;

  assign idx_we  = reg_we && (reg_sel == SEL_INDEX);
  assign win_we  = reg_we && (reg_sel == SEL_WINDOW);
  assign eoi_we  = reg_we && (reg_sel == SEL_EOI);
  assign off     = idx_q - ENT_BASE;
  assign in_tab  = (int'(idx_q) >= ENT_FIRST) && (int'(idx_q) <= ENT_LAST);
  assign hi_half = off[0];

  for (genvar n = 0; n < NUM_ENT; n++) begin : g_hit
    assign ent_hit[n] = in_tab && (off[7:1] == 7'(n));
  end

  always_comb begin
    for (int n = 0; n < NUM_ENT; n++) begin
      ent_nxt[n] = ent_q[n];
      if (win_we && ent_hit[n])
        ent_nxt[n] = hi_half ? rte_put_high(ent_q[n], reg_wdata)
                             : rte_put_low(ent_q[n], reg_wdata);
      if (eoi_we && (reg_wdata[7:0] == ent_q[n].vct)) ent_nxt[n].rirr = 1'b0;
      if (rirr_set[n]) ent_nxt[n].rirr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= 8'd0;
      apic_id_q <= 4'd0;
      for (int n = 0; n < NUM_ENT; n++) ent_q[n] <= RTE_RESET;
    end else begin
      if (idx_we) idx_q <= reg_wdata[7:0];
      if (win_we && (idx_q == 8'd0)) apic_id_q <= reg_wdata[27:24];
      for (int n = 0; n < NUM_ENT; n++) ent_q[n] <= ent_nxt[n];
    end
  end

  always_comb begin
    win_rd = 32'd0;
    if (idx_q == 8'd0)      win_rd = {4'd0, apic_id_q, 24'd0};
    else if (idx_q == 8'd1) win_rd = VERSION_WORD;
    else begin
      for (int n = 0; n < NUM_ENT; n++)
        if (ent_hit[n])
          win_rd = hi_half ? rte_high(ent_q[n]) : rte_low(ent_q[n], ds_vec[n]);
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_INDEX:  reg_rdata = {24'd0, idx_q};
      SEL_WINDOW: reg_rdata = win_rd;
      default:    reg_rdata = 32'd0;
    endcase
  end

  always_comb begin
    for (int n = 0; n < NUM_ENT; n++) ents[n] = ent_q[n];
  end

  // R4: a window write to an unmapped index leaves the table unchanged
  a_r4_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && !in_tab && (idx_q > 8'd1) && (rirr_set == '0) && !eoi_we) |=> $stable(ents));

  for (genvar n = 0; n < NUM_ENT; n++) begin : g_eoi_chk
    // R10: a matching end-of-interrupt clears the remote-pending flag
    a_r10_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_we && (reg_wdata[7:0] == ents[n].vct) && !rirr_set[n]) |=> !ents[n].rirr);
  end

endmodule

// File: rtl/irq_redir_src.sv
module irq_redir_src #(
  parameter int NUM_ENT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] irq_in,
  input  logic [NUM_ENT-1:0] mask_vec,
  input  logic [NUM_ENT-1:0] tm_vec,
  input  logic [NUM_ENT-1:0] rirr_vec,
  input  logic [NUM_ENT-1:0] launch,
  output logic [NUM_ENT-1:0] req
);

  logic [NUM_ENT-1:0] irq_q;
  logic [NUM_ENT-1:0] edge_pend;
  logic [NUM_ENT-1:0] rise;
  logic [NUM_ENT-1:0] level_req;

  assign rise      = irq_in & ~irq_q;
  assign level_req = irq_in & tm_vec & ~rirr_vec;
  assign req       = (edge_pend | level_req) & ~mask_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= '0;
      edge_pend <= '0;
    end else begin
      irq_q     <= irq_in;
      edge_pend <= ((edge_pend & ~launch) | rise) & ~mask_vec & ~tm_vec;
    end
  end

  // R8: an edge entry only becomes pending after a rising edge of its input
  for (genvar n = 0; n < NUM_ENT; n++) begin : g_edge_chk
    a_r8_pend_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edge_pend[n]) |-> $past(irq_in[n]) && !$past(irq_q[n]));
  end

endmodule

// File: rtl/irq_redir_arb.sv
module irq_redir_arb
  import irq_redir_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] req,
  input  rte_t [NUM_ENT-1:0] ents,
  input  logic               msg_ready,
  output logic [NUM_ENT-1:0] launch,
  output logic [NUM_ENT-1:0] owner,
  output logic               msg_valid,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data
);

  logic [NUM_ENT-1:0] grant;
  rte_t               sel_e;

  assign grant  = req & (~req + NUM_ENT'(1));
  assign launch = msg_valid ? '0 : grant;

  always_comb begin
    sel_e = RTE_RESET;
    for (int n = 0; n < NUM_ENT; n++)
      if (grant[n]) sel_e = ents[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= 32'd0;
      msg_data  <= 32'd0;
      owner     <= '0;
    end else if (launch != '0) begin
      msg_valid <= 1'b1;
      msg_addr  <= msi_addr(sel_e);
      msg_data  <= msi_data(sel_e);
      owner     <= grant;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
      owner     <= '0;
    end
  end

  a_r12_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  a_r11_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch));

  a_r11_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (launch != '0) |-> ((req & (launch - NUM_ENT'(1))) == '0));

  a_r5_addr_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[31:20] == MSG_PREFIX) && (msg_addr[1:0] == 2'b00));

  a_r6_data_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[14] && (msg_data[31:16] == 16'd0) && (msg_data[13:12] == 2'b00));

endmodule

// File: rtl/irq_redir_msi.sv
module irq_redir_msi
  import irq_redir_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_ENT-1:0] irq_in,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data
);

  rte_t [NUM_ENT-1:0] ents;
  logic [NUM_ENT-1:0] mask_vec, tm_vec, rirr_vec;
  logic [NUM_ENT-1:0] req, launch, owner, accept_vec, rirr_set, ds_vec;

  always_comb begin
    for (int n = 0; n < NUM_ENT; n++) begin
      mask_vec[n] = ents[n].mask;
      tm_vec[n]   = ents[n].tm;
      rirr_vec[n] = ents[n].rirr;
    end
  end

  assign accept_vec = owner & {NUM_ENT{msg_valid && msg_ready}};
  assign rirr_set   = accept_vec & tm_vec;
  assign ds_vec     = req | owner;

  irq_redir_table #(.NUM_ENT(NUM_ENT)) u_table (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rirr_set(rirr_set),
    .ds_vec(ds_vec), .ents(ents)
  );

  irq_redir_src #(.NUM_ENT(NUM_ENT)) u_src (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_vec(mask_vec),
    .tm_vec(tm_vec), .rirr_vec(rirr_vec), .launch(launch), .req(req)
  );

  irq_redir_arb #(.NUM_ENT(NUM_ENT)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .ents(ents), .msg_ready(msg_ready),
    .launch(launch), .owner(owner), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  a_r7_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (launch & mask_vec) == '0);

  a_r9_no_resend: assert property (@(posedge clk) disable iff (!rst_n)
    (launch & tm_vec & rirr_vec) == '0);

  for (genvar n = 0; n < NUM_ENT; n++) begin : g_rirr_chk
    a_r9_rirr_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_vec[n] && tm_vec[n]) |=> rirr_vec[n]);
  end

endmodule

// File: tb/irq_redir_msi_tb_top.sv
module irq_redir_msi_tb_top;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [N-1:0] irq_in = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [31:0] msg_addr, msg_data;

  always #10 clk = ~clk;

  irq_redir_msi #(.NUM_ENT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q[$];
  logic [63:0] mon_exp;
  logic [7:0] b_vct [N];
  logic [2:0] b_dlm [N];
  logic       b_dsm [N];
  logic       b_tm  [N];
  logic [7:0] b_did [N];
  logic [7:0] b_edid[N];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic rd_win(input logic [7:0] idx, output logic [31:0] v);
    wr(2'd0, {24'd0, idx});
    reg_sel = 2'd1; #1;
    v = reg_rdata;
    reg_sel = 2'd3;
  endtask

  task automatic cfg(input int n, input logic [7:0] vct, input logic [2:0] dlm, input logic dsm,
                     input logic tm, input logic msk, input logic [7:0] did, input logic [7:0] edid);
    b_vct[n] = vct; b_dlm[n] = dlm; b_dsm[n] = dsm; b_tm[n] = tm; b_did[n] = did; b_edid[n] = edid;
    wr(2'd0, 32'(16 + 2 * n));
    wr(2'd1, (32'(msk) << 16) | (32'(tm) << 15) | (32'(dsm) << 11) | (32'(dlm) << 8) | 32'(vct));
    wr(2'd0, 32'(17 + 2 * n));
    wr(2'd1, {did, edid, 16'd0});
  endtask

  // expected message of entry n, built from the stated field positions
  task automatic push(input int n);
    logic [31:0] a, d;
    a = 32'hFEE0_0000 + (32'(b_did[n]) * 32'h1000) + (32'(b_edid[n]) * 32'h10)
        + ((b_dlm[n] == 3'd1) ? 32'd8 : 32'd0) + (b_dsm[n] ? 32'd4 : 32'd0);
    d = 32'h4000 + (b_tm[n] ? 32'h8000 : 32'd0) + (b_dsm[n] ? 32'h800 : 32'd0)
        + (32'(b_dlm[n]) * 32'h100) + 32'(b_vct[n]);
    exp_q.push_back({a, d});
  endtask

  // monitor: compares every accepted message against the scoreboard
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7/R8/R9 unexpected message actual %h_%h expected none", msg_addr, msg_data);
      end else begin
        mon_exp = exp_q.pop_front();
        chk("R5 message address", msg_addr, mon_exp[63:32]);
        chk("R6 message data", msg_data, mon_exp[31:0]);
      end
    end
  end

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(64'd20 * 64'd150000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, a0, d0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    chk("R1 valid low", 32'(msg_valid), 32'd0);
    for (int n = 0; n < N; n++) begin
      rd_win(8'(16 + 2 * n), v); chk("R1 entry low", v, 32'h0001_0000);
      rd_win(8'(17 + 2 * n), v); chk("R1 entry high", v, 32'd0);
    end

    // R3 identification and version
    rd_win(8'd1, v); chk("R3 version", v, 32'h0007_0020);
    wr(2'd1, 32'hFFFF_FFFF);
    rd_win(8'd1, v); chk("R3 version read-only", v, 32'h0007_0020);
    wr(2'd0, 32'd0); wr(2'd1, 32'hFFFF_FFFF);
    rd_win(8'd0, v); chk("R3 id writable bits", v, 32'h0F00_0000);

    // R4 unmapped indices
    wr(2'd0, 32'h05); wr(2'd1, 32'hFFFF_FFFF);
    rd_win(8'h05, v); chk("R4 unmapped read", v, 32'd0);
    wr(2'd0, 32'h20); wr(2'd1, 32'hFFFF_FFFF);
    rd_win(8'h20, v); chk("R4 past table read", v, 32'd0);
    rd_win(8'h1F, v); chk("R4 last entry untouched", v, 32'd0);
    reg_sel = 2'd3; #1; chk("R4 unused select", reg_rdata, 32'd0);

    // R2 index readback and entry layout, reserved and read-only bits ignored
    wr(2'd0, 32'h13); reg_sel = 2'd0; #1; chk("R2 index readback", reg_rdata, 32'h13);
    wr(2'd0, 32'h18); wr(2'd1, 32'h8001_DD9C);
    rd_win(8'h18, v); chk("R2 low half layout", v, 32'h0001_8D9C);
    wr(2'd0, 32'h19); wr(2'd1, 32'hA57E_FFFF);
    rd_win(8'h19, v); chk("R2 high half layout", v, 32'hA57E_0000);

    // R8 edge entry, with hint and destination mode set (R5, R6)
    cfg(1, 8'h41, 3'd1, 1'b1, 1'b0, 1'b0, 8'h5A, 8'h3C);
    push(1);
    irq_in[1] = 1'b1; cyc(20);
    chk("R8 one message per edge", 32'(exp_q.size()), 32'd0);
    irq_in[1] = 1'b0; cyc(3);
    push(1);
    irq_in[1] = 1'b1; cyc(20);
    chk("R8 second edge sends again", 32'(exp_q.size()), 32'd0);
    irq_in[1] = 1'b0;

    // R7 masked entry stays silent, masked edge discarded
    cfg(3, 8'h33, 3'd0, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00);
    irq_in[3] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); chk("R7 masked quiet", 32'(msg_valid), 32'd0);
    end
    @(posedge clk); #1;
    irq_in[3] = 1'b0;
    cfg(3, 8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 8'h03, 8'h00);
    cyc(10);
    chk("R7 dropped edge not sent after unmask", 32'(msg_valid), 32'd0);

    // R9 level entry: one message, then remote-pending blocks
    cfg(5, 8'h55, 3'd0, 1'b0, 1'b1, 1'b0, 8'h01, 8'h00);
    push(5);
    irq_in[5] = 1'b1; cyc(20);
    chk("R9 single level message", 32'(exp_q.size()), 32'd0);
    rd_win(8'h1A, v); chk("R9 remote-pending set", v & 32'h4000, 32'h4000);
    cfg(6, 8'h66, 3'd0, 1'b0, 1'b1, 1'b0, 8'h02, 8'h00);
    push(6);
    irq_in[6] = 1'b1; cyc(20);

    // R10 end-of-interrupt: upper bits ignored, other vectors untouched
    push(5);
    wr(2'd2, 32'hABCD_EF55); cyc(20);
    chk("R10 matching entry resends", 32'(exp_q.size()), 32'd0);
    rd_win(8'h1C, v); chk("R10 other vector keeps flag", v & 32'h4000, 32'h4000);
    irq_in[5] = 1'b0;
    push(6);
    wr(2'd2, 32'h1234_5666); cyc(20);
    chk("R10 second vector resends", 32'(exp_q.size()), 32'd0);
    irq_in[6] = 1'b0;
    wr(2'd2, 32'h55); wr(2'd2, 32'h66); cyc(10);
    rd_win(8'h1A, v); chk("R10 flag cleared entry 5", v & 32'h4000, 32'd0);
    rd_win(8'h1C, v); chk("R10 flag cleared entry 6", v & 32'h4000, 32'd0);

    // R11 ordering, R12 hold under back-pressure, R13 delivery status
    cfg(2, 8'h22, 3'd2, 1'b0, 1'b0, 1'b0, 8'h22, 8'h11);
    cfg(6, 8'h76, 3'd0, 1'b1, 1'b0, 1'b0, 8'h66, 8'h99);
    cfg(7, 8'h77, 3'd1, 1'b0, 1'b0, 1'b0, 8'h77, 8'h01);
    rd_win(8'h1E, v); chk("R13 idle status clear", v & 32'h1000, 32'd0);
    msg_ready = 1'b0;
    push(2); push(6); push(7);
    irq_in[2] = 1'b1; irq_in[6] = 1'b1; irq_in[7] = 1'b1;
    cyc(4);
    @(negedge clk);
    a0 = msg_addr; d0 = msg_data;
    chk("R11 valid under stall", 32'(msg_valid), 32'd1);
    chk("R11 lowest entry first", 32'(d0[7:0]), 32'h22);
    @(posedge clk); #1;
    rd_win(8'h14, v); chk("R13 outstanding status", v & 32'h1000, 32'h1000);
    rd_win(8'h1E, v); chk("R13 waiting status", v & 32'h1000, 32'h1000);
    cyc(3);
    @(negedge clk);
    chk("R12 valid held", 32'(msg_valid), 32'd1);
    chk("R12 address held", msg_addr, a0);
    chk("R12 data held", msg_data, d0);
    @(posedge clk); #1;
    msg_ready = 1'b1;
    cyc(20);
    chk("R11 all sent in order", 32'(exp_q.size()), 32'd0);
    rd_win(8'h1E, v); chk("R13 status clear after send", v & 32'h1000, 32'd0);
    irq_in = '0;
    cyc(10);
    chk("R8 no stray messages", 32'(exp_q.size()), 32'd0);

    summary();
    $finish;
  end

endmodule